// File: doc/BRIEF.md
# Flash Protected-Range Access Guard

The guard sits between a flash command source and the serial flash engine. Each flash cycle is described by a type code, a start byte address and a byte count. The guard compares the whole address span of the cycle against a bank of protected ranges. It either lets the cycle through onto the serial bus with a one-clock `permit` pulse, or it refuses the cycle. A refused cycle produces a one-clock `done` pulse together with `acc_err`. That access-error flag is separate from any cycle error the engine reports later. A permitted cycle does not raise `done` here, because the engine finishes it.

Each range register holds a base granule and an inclusive limit granule, where a granule is 4 KiB. It also holds one enable for read protection and one for write protection, and the two are independent. Read-type cycles are tested only against read-protected ranges. Write-type cycles, erases and status writes are tested only against write-protected ranges. The last register is a general-purpose range and is checked like the others. Boot firmware programs the ranges and then raises `lock_req`. From then until reset the bank refuses every further register write.

The controller is a four-state machine. IDLE waits for `cyc_valid` and moves to CHECK when it arrives, latching the cycle. CHECK evaluates the overlap and moves to DENY on a hit or to GRANT otherwise. GRANT drives `permit` for one clock and returns to IDLE. DENY drives `done` and `acc_err` for one clock and returns to IDLE.

Top module: `prg_guard`

## Requirements
- R1: After reset the guard is in IDLE with `idle`=1 and `permit`, `done` and `acc_err` at 0. Every range is cleared, so any cycle is permitted.
- R2: A cycle is accepted on a clock edge where `cyc_valid`=1 and `idle`=1. `idle` is 0 for the next two clocks. The outcome pulse (`permit`, or `done` with `acc_err`) is high during the second clock after acceptance, for exactly one clock, and IDLE follows.
- R3: A range word takes its base granule from bits 13:0 and its limit granule from bits 29:16. The range covers byte addresses base*4096 through limit*4096+0xFFF inclusive, so the bytes just below and just above it are outside.
- R4: Bit 15 of a range word enables read protection. It blocks read (type 0) and read-ID (type 6) cycles that overlap the range, and has no effect on write-type cycles.
- R5: Bit 31 of a range word enables write protection. It blocks write (type 2), 4 KiB erase (type 3), 64 KiB erase (type 4) and status-write (type 7) cycles that overlap the range, and has no effect on reads.
- R6: A range with neither enable bit set is ignored. A range whose base is greater than its limit covers no address.
- R7: The checked span runs from the start address through start plus length minus one. The length is `cyc_len_m1`+1 bytes for non-erase cycles, 4096 for type 3 and 65536 for type 4. Overlap of any single byte blocks the cycle.
- R8: A blocked cycle gives `done`=1 and `acc_err`=1 with `permit`=0. A permitted cycle gives `permit`=1 with `done`=0 and `acc_err`=0.
- R9: Once `lock_req` has been sampled high, register writes are ignored until reset, and the ranges keep their values.
- R10: All NUM_RANGES registers are checked, including the last, general-purpose one. Read-status (type 8) cycles are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Range register write strobe |
| reg_idx | input | IDX_W | Range register index |
| reg_wdata | input | 32 | Range register write word |
| lock_req | input | 1 | Sets the lock-down flag |
| cyc_valid | input | 1 | Flash cycle request |
| cyc_kind | input | 4 | Flash cycle type code |
| cyc_addr | input | ADDR_W | Start byte address |
| cyc_len_m1 | input | LEN_W | Byte count minus one (non-erase cycles) |
| idle | output | 1 | Guard ready for a new cycle |
| permit | output | 1 | Cycle may go onto the serial bus |
| done | output | 1 | Cycle finished by the guard (blocked) |
| acc_err | output | 1 | Access error: cycle hit a protected range |

## Verification
The bench builds the guard with its default parameters: six ranges, a 24-bit byte address and a 6-bit length field covering 1 to 64 bytes. With these values the 64-byte spans land one byte either side of a granule edge, and a 64 KiB erase spans sixteen granules. That lets one erase reach a range that is inverted but otherwise overlapped, and the general-purpose range at index 5 can be loaded. The 3-bit index also has codes 6 and 7 that address no register.

// File: rtl/prg_pkg.sv
package prg_pkg;
    localparam int FIELD_W   = 14;
    localparam int GRAN_SH   = 12;
    localparam int LIMIT_LSB = 16;
    localparam int RP_BIT    = 15;
    localparam int WP_BIT    = 31;

    typedef enum logic [3:0] {
        CY_READ     = 4'd0,
        CY_WRITE    = 4'd2,
        CY_ERASE4K  = 4'd3,
        CY_ERASE64K = 4'd4,
        CY_RDID     = 4'd6,
        CY_WRSR     = 4'd7,
        CY_RDSR     = 4'd8
    } cyc_kind_e;

    typedef struct packed {
        logic               wp;
        logic               rp;
        logic [FIELD_W-1:0] limit;
        logic [FIELD_W-1:0] base;
    } range_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_GRANT = 2'd2,
        ST_DENY  = 2'd3
    } guard_state_e;
endpackage

// File: rtl/prg_range_bank.sv
module prg_range_bank
    import prg_pkg::*;
#(
    parameter int NUM_RANGES = 6,
    parameter int IDX_W      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [IDX_W-1:0]           reg_idx,
    input  logic [31:0]                reg_wdata,
    input  logic                       lock_req,
    output range_t [NUM_RANGES-1:0]    ranges,
    output logic                       locked
);
    range_t new_word;
    logic   unused_bit30;

    assign unused_bit30 = reg_wdata[30];

    always_comb begin
        new_word.base  = reg_wdata[FIELD_W-1:0];
        new_word.limit = reg_wdata[LIMIT_LSB+FIELD_W-1:LIMIT_LSB];
        new_word.rp    = reg_wdata[RP_BIT];
        new_word.wp    = reg_wdata[WP_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (lock_req)
            locked <= 1'b1;
    end

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                ranges[i] <= '0;
            else if (reg_we && !locked && (reg_idx == IDX_W'(i)))
                ranges[i] <= new_word;
        end
    end
endmodule

// File: rtl/prg_span_calc.sv
module prg_span_calc
    import prg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 6
) (
    input  logic [3:0]                kind,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LEN_W-1:0]          len_m1,
    output logic                      is_rd,
    output logic                      is_wr,
    output logic [ADDR_W-GRAN_SH-1:0] start_g,
    output logic [ADDR_W-GRAN_SH:0]   end_g
);
    localparam int SPAN_W = ADDR_W + 1;

    logic [SPAN_W-1:0]  span_m1;
    logic [SPAN_W-1:0]  end_a;
    logic [GRAN_SH-1:0] unused_low;

    always_comb begin
        is_rd   = 1'b0;
        is_wr   = 1'b0;
        span_m1 = SPAN_W'(len_m1);
        case (kind)
            CY_READ, CY_RDID:  is_rd = 1'b1;
            CY_WRITE, CY_WRSR: is_wr = 1'b1;
            CY_ERASE4K: begin
                is_wr   = 1'b1;
                span_m1 = SPAN_W'(4095);
            end
            CY_ERASE64K: begin
                is_wr   = 1'b1;
                span_m1 = SPAN_W'(65535);
            end
            default: ;
        endcase
    end

    assign end_a      = {1'b0, addr} + span_m1;
    assign start_g    = addr[ADDR_W-1:GRAN_SH];
    assign end_g      = end_a[SPAN_W-1:GRAN_SH];
    assign unused_low = end_a[GRAN_SH-1:0];
endmodule

// File: rtl/prg_range_match.sv
module prg_range_match
    import prg_pkg::*;
#(
    parameter int NUM_RANGES = 6,
    parameter int GA         = 12
) (
    input  range_t [NUM_RANGES-1:0] ranges,
    input  logic                    is_rd,
    input  logic                    is_wr,
    input  logic [GA-1:0]           start_g,
    input  logic [GA:0]             end_g,
    output logic                    hit
);
    localparam int CMP_W = (GA + 1 > FIELD_W) ? GA + 1 : FIELD_W;

    logic [NUM_RANGES-1:0] hit_vec;
    logic [CMP_W-1:0]      s_x;
    logic [CMP_W-1:0]      e_x;

    assign s_x = CMP_W'(start_g);
    assign e_x = CMP_W'(end_g);

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
        logic [CMP_W-1:0] b_x;
        logic [CMP_W-1:0] l_x;
        logic             armed;
        assign b_x   = CMP_W'(ranges[i].base);
        assign l_x   = CMP_W'(ranges[i].limit);
        assign armed = (ranges[i].rp && is_rd) || (ranges[i].wp && is_wr);
        assign hit_vec[i] = armed && (b_x <= l_x) && (s_x <= l_x) && (e_x >= b_x);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/prg_guard.sv
module prg_guard
    import prg_pkg::*;
#(
    parameter int NUM_RANGES = 6,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 6,
    parameter int IDX_W      = $clog2(NUM_RANGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    input  logic              lock_req,
    input  logic              cyc_valid,
    input  logic [3:0]        cyc_kind,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [LEN_W-1:0]  cyc_len_m1,
    output logic              idle,
    output logic              permit,
    output logic              done,
    output logic              acc_err
);
    localparam int GA = ADDR_W - GRAN_SH;

    guard_state_e            state, state_nx;
    range_t [NUM_RANGES-1:0] ranges;
    logic                    locked;
    logic [3:0]              kind_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [LEN_W-1:0]        len_q;
    logic                    is_rd, is_wr, hit;
    logic [GA-1:0]           start_g;
    logic [GA:0]             end_g;

    prg_range_bank #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .lock_req(lock_req), .ranges(ranges),
        .locked(locked)
    );

    prg_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
        .kind(kind_q), .addr(addr_q), .len_m1(len_q), .is_rd(is_rd),
        .is_wr(is_wr), .start_g(start_g), .end_g(end_g)
    );

    prg_range_match #(.NUM_RANGES(NUM_RANGES), .GA(GA)) u_match (
        .ranges(ranges), .is_rd(is_rd), .is_wr(is_wr), .start_g(start_g),
        .end_g(end_g), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else if (state == ST_IDLE && cyc_valid) begin
            kind_q <= cyc_kind;
            addr_q <= cyc_addr;
            len_q  <= cyc_len_m1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cyc_valid) state_nx = ST_CHECK;
            ST_CHECK: state_nx = hit ? ST_DENY : ST_GRANT;
            ST_GRANT: state_nx = ST_IDLE;
            ST_DENY:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle    = 1'b0;
        permit  = 1'b0;
        done    = 1'b0;
        acc_err = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_CHECK: ;
            ST_GRANT: permit = 1'b1;
            ST_DENY: begin
                done    = 1'b1;
                acc_err = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/prg_guard_chk.sv
module prg_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_valid,
    input logic idle,
    input logic permit,
    input logic done,
    input logic acc_err,
    input logic locked
);
    // R8
    excl_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(permit && acc_err));

    // R8
    grant_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> !done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && idle) |=> !idle);

    // R2
    outcome_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && idle) |=> ##1 (permit || acc_err));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (permit || done) |=> idle);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

bind prg_guard prg_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .idle(idle),
    .permit(permit), .done(done), .acc_err(acc_err), .locked(locked)
);

// File: tb/prg_guard_test.sv
`timescale 1ns/1ps
module prg_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        lock_req = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [3:0]  cyc_kind = '0;
    logic [23:0] cyc_addr = '0;
    logic [5:0]  cyc_len_m1 = '0;
    logic        idle, permit, done, acc_err;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    prg_guard uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .lock_req(lock_req), .cyc_valid(cyc_valid),
        .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .cyc_len_m1(cyc_len_m1),
        .idle(idle), .permit(permit), .done(done), .acc_err(acc_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int b, input int l, input bit rp, input bit wp);
        return {wp, 1'b0, 14'(l), rp, 1'b0, 14'(b)};
    endfunction

    task automatic wr_reg(input int idx, input logic [31:0] w);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // one flash cycle; expect blocked (1) or permitted (0)
    task automatic run_cyc(input string tag, input int kind, input int addr,
                           input int len_m1, input bit blocked);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_kind = 4'(kind); cyc_addr = 24'(addr);
        cyc_len_m1 = 6'(len_m1);
        @(posedge clk);
        @(negedge clk);
        cyc_valid = 1'b0;
        check({tag, " R2 busy"}, int'(idle), 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 permit"}, int'(permit), blocked ? 0 : 1);
        check({tag, " R8 acc_err"}, int'(acc_err), blocked ? 1 : 0);
        check({tag, " R8 done"}, int'(done), blocked ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 back idle"}, int'(idle), 1);
        check({tag, " R2 one pulse"}, int'(permit | done), 0);
    endtask

    task automatic t_reset();
        check("R1 idle", int'(idle), 1);
        check("R1 permit", int'(permit), 0);
        check("R1 done", int'(done), 0);
        check("R1 acc_err", int'(acc_err), 0);
        run_cyc("R1 clear write", 2, 'h2000, 0, 0);
        run_cyc("R1 clear read", 0, 'h10000, 3, 0);
    endtask

    task automatic t_fields();
        wr_reg(0, mk('h2, 'h3, 0, 1));
        run_cyc("R3 below", 2, 'h1FFF, 0, 0);
        run_cyc("R3 base", 2, 'h2000, 0, 1);
        run_cyc("R3 top", 2, 'h3FFF, 0, 1);
        run_cyc("R3 above", 2, 'h4000, 0, 0);
        run_cyc("R7 span ends below", 2, 'h1FC0, 63, 0);
        run_cyc("R7 span last byte in", 2, 'h1FC1, 63, 1);
    endtask

    task automatic t_read_prot();
        wr_reg(1, mk('h10, 'h10, 1, 0));
        run_cyc("R4 read", 0, 'h10000, 0, 1);
        run_cyc("R4 readid", 6, 'h10800, 3, 1);
        run_cyc("R4 write unaffected", 2, 'h10000, 0, 0);
        run_cyc("R10 rdsr", 8, 'h10000, 0, 0);
    endtask

    task automatic t_write_prot();
        run_cyc("R5 read unaffected", 0, 'h2000, 0, 0);
        run_cyc("R7 erase4k clear", 3, 'h1000, 0, 0);
        run_cyc("R7 erase4k reach", 3, 'h1800, 0, 1);
        run_cyc("R5 erase64k", 4, 'h0, 0, 1);
        run_cyc("R5 wrsr", 7, 'h2000, 0, 1);
    endtask

    task automatic t_ignored();
        wr_reg(2, mk('h20, 'h20, 0, 0));
        run_cyc("R6 no enables", 2, 'h20000, 0, 0);
        wr_reg(3, mk('h31, 'h30, 1, 1));
        run_cyc("R6 inverted", 4, 'h30000, 0, 0);
    endtask

    task automatic t_last();
        wr_reg(5, mk('h50, 'h5F, 0, 1));
        run_cyc("R10 last range", 2, 'h5F800, 0, 1);
        run_cyc("R10 last range read", 0, 'h5F800, 0, 0);
    endtask

    task automatic t_lock();
        @(negedge clk);
        lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0;
        wr_reg(0, 32'h0);
        run_cyc("R9 range0 kept", 2, 'h2000, 0, 1);
        wr_reg(4, mk('h60, 'h60, 0, 1));
        run_cyc("R9 range4 not loaded", 2, 'h60000, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_read_prot();
        t_write_prot();
        t_ignored();
        t_last();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R2 actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule